// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit supplies the timing state behind deadline instructions in a processor that interleaves several hardware threads through one pipeline. Each thread owns a countdown timer that moves one step for every pipeline slot that thread occupies. When a deadline instruction arrives for a thread whose timer has not yet expired, the unit asks the pipeline to replay that instruction: the next PC is the current PC, so the thread tries again on its next turn. Once the timer has run out, the instruction completes, the timer takes the new budget carried by the instruction, and the PC advances.

A timer that expires while its thread is still running ordinary code means the budget was overrun. The unit remembers this in a sticky per-thread miss flag. The branching form of the deadline instruction checks that flag. If the flag is set, it raises an exception strobe and sends the thread to a handler address given with the instruction. It also reloads the timer and clears the flag. A budget of zero means the thread has no deadline to meet.

The unit works on one slot per cycle. Each slot carries a thread index, an operation code, a budget value, the current PC and the handler address. The unit answers in the same cycle with the stall decision, the next PC and the exception strobe. Its per-thread state updates at the clock edge that ends the slot.

Top module: `deadline_timer_unit`

## Requirements
- R1: After reset every thread's timer is zero and its miss flag is clear, so a first deadline instruction on any thread completes without stalling or raising an exception.
- R2: A deadline instruction (op code 1, or op code 2 with the miss flag clear) whose thread timer is nonzero asserts stall_o, holds next_pc_o equal to pc_i and keeps exc_o low.
- R3: A deadline instruction whose thread timer is zero completes. stall_o is low, next_pc_o equals pc_i + 4, and the thread's timer is loaded with budget_i.
- R4: Each valid slot that does not complete a deadline instruction lowers that thread's nonzero timer by exactly one. Other threads' timers, and every timer during a slot with valid_i low, are unchanged.
- R5: A timer at zero stays at zero and never wraps.
- R6: A thread's miss flag is set when the thread has a valid slot with a non-deadline op (op code 0 or 3), its timer is zero, and a nonzero budget has been loaded since the last miss or completion with zero budget.
- R7: A budget of zero places no constraint. The thread's next deadline instruction completes at once, and no miss is recorded however long the thread runs.
- R8: The branching deadline instruction (op code 2) on a thread whose miss flag is set raises exc_o for that slot. It sets next_pc_o to handler_i, does not stall, loads the timer with budget_i and clears the miss flag.
- R9: Op code 2 with the miss flag clear behaves exactly like op code 1.
- R10: The plain deadline instruction (op code 1) does not clear the miss flag. A later op code 2 still takes the exception.
- R11: Op codes 0 and 3, and slots with valid_i low, never stall or raise exc_o. For these, next_pc_o equals pc_i + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A thread occupies this pipeline slot |
| tid_i | input | 3 | Thread index of the slot (0 to 5) |
| op_i | input | 2 | 0 ordinary, 1 deadline, 2 branching deadline, 3 ordinary |
| budget_i | input | 16 | New deadline value in thread iterations |
| pc_i | input | 32 | PC of the instruction in the slot |
| handler_i | input | 32 | Exception target for the branching form |
| stall_o | output | 1 | Replay the instruction on the thread's next turn |
| next_pc_o | output | 32 | PC the thread fetches next |
| exc_o | output | 1 | Deadline miss exception strobe |

## Verification
The assertions take for granted that tid_i is below the thread count whenever valid_i is high. They also assume the slot inputs are settled before the clock edge, so the combinational answers and the state update refer to the same instruction. Round-robin order is not assumed: the timers only count slots that name their thread. The stimulus draws thread indices from 0 to 5, inserts idle slots with valid_i low, and sometimes drives the reserved op code 3. It then predicts each answer from a per-thread timer, armed bit and miss flag that it keeps itself.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN   = 2'd0,
    OP_DEAD    = 2'd1,
    OP_DEAD_BR = 2'd2,
    OP_RSVD    = 2'd3
  } dl_op_e;
endpackage

// File: rtl/dtu_thread_timer.sv
module dtu_thread_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               iter_i,
  input  logic               dead_op_i,
  input  logic               complete_i,
  input  logic               clr_miss_i,
  input  logic [TIMER_W-1:0] load_val_i,
  output logic [TIMER_W-1:0] timer_o,
  output logic               miss_o
);
  logic [TIMER_W-1:0] timer_q;
  logic               armed_q;
  logic               miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      armed_q <= 1'b0;
      miss_q  <= 1'b0;
    end else if (iter_i) begin
      if (complete_i) begin
        timer_q <= load_val_i;
        armed_q <= |load_val_i;
      end else if (timer_q != '0) begin
        timer_q <= timer_q - 1'b1;
      end else if (armed_q && !dead_op_i) begin
        // budget overrun: expired while still running ordinary code
        miss_q  <= 1'b1;
        armed_q <= 1'b0;
      end
      if (clr_miss_i) miss_q <= 1'b0;
    end
  end

  assign timer_o = timer_q;
  assign miss_o  = miss_q;

  AST_SAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_i && !complete_i && timer_q == '0 |=> timer_q == '0); // R5
  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_i && !complete_i && timer_q != '0 |=> timer_q == $past(timer_q) - 1'b1); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iter_i |=> $stable(timer_q) && $stable(miss_q)); // R4
  AST_LOAD_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_i && complete_i |=> timer_q == $past(load_val_i)); // R3
  AST_MISS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_i && clr_miss_i |=> !miss_q); // R8
  AST_ZERO_NO_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_i && complete_i && load_val_i == '0 && !miss_q |=> !miss_q); // R7
endmodule

// File: rtl/dtu_issue_ctrl.sv
module dtu_issue_ctrl
  import dtu_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic               valid_i,
  input  logic [1:0]         op_i,
  input  logic [TIMER_W-1:0] timer_i,
  input  logic               miss_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    handler_i,
  output logic               stall_o,
  output logic               exc_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               dead_op_o,
  output logic               complete_o,
  output logic               clr_miss_o
);
  dl_op_e op;
  logic   take_exc;

  always_comb begin
    op         = dl_op_e'(op_i);
    dead_op_o  = valid_i && (op == OP_DEAD || op == OP_DEAD_BR);
    take_exc   = valid_i && op == OP_DEAD_BR && miss_i;
    stall_o    = dead_op_o && !take_exc && timer_i != '0;
    complete_o = dead_op_o && !stall_o;
    clr_miss_o = take_exc;
    exc_o      = take_exc;
    if (take_exc)     next_pc_o = handler_i;
    else if (stall_o) next_pc_o = pc_i;
    else              next_pc_o = pc_i + PC_W'(PC_STEP);
  end
endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit #(
  parameter int NUM_THREADS = 6,
  parameter int TIMER_W     = 16,
  parameter int PC_W        = 32,
  parameter int PC_STEP     = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [TID_W-1:0]   tid_i,
  input  logic [1:0]         op_i,
  input  logic [TIMER_W-1:0] budget_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    handler_i,
  output logic               stall_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               exc_o
);
  logic [TIMER_W-1:0] timer_w [NUM_THREADS];
  logic [NUM_THREADS-1:0] miss_w;
  logic [NUM_THREADS-1:0] iter_w;
  logic [TIMER_W-1:0] sel_timer;
  logic               sel_miss;
  logic               dead_op, complete, clr_miss;

  always_comb begin
    sel_timer = '0;
    sel_miss  = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (tid_i == TID_W'(t)) begin
        sel_timer = timer_w[t];
        sel_miss  = miss_w[t];
      end
    end
  end

  dtu_issue_ctrl #(
    .TIMER_W (TIMER_W),
    .PC_W    (PC_W),
    .PC_STEP (PC_STEP)
  ) ctrl_i (
    .valid_i    (valid_i),
    .op_i       (op_i),
    .timer_i    (sel_timer),
    .miss_i     (sel_miss),
    .pc_i       (pc_i),
    .handler_i  (handler_i),
    .stall_o    (stall_o),
    .exc_o      (exc_o),
    .next_pc_o  (next_pc_o),
    .dead_op_o  (dead_op),
    .complete_o (complete),
    .clr_miss_o (clr_miss)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign iter_w[t] = valid_i && (tid_i == TID_W'(t));
    dtu_thread_timer #(.TIMER_W(TIMER_W)) tmr_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .iter_i     (iter_w[t]),
      .dead_op_i  (dead_op),
      .complete_i (complete),
      .clr_miss_i (clr_miss),
      .load_val_i (budget_i),
      .timer_o    (timer_w[t]),
      .miss_o     (miss_w[t])
    );
  end

  AST_TID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> int'(tid_i) < NUM_THREADS); // R4
  AST_ONE_ITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(iter_w)); // R4
  AST_STALL_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> next_pc_o == pc_i && !exc_o); // R2
  AST_STALL_NEEDS_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> sel_timer != '0); // R2
  AST_EXC_TO_HANDLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !stall_o && next_pc_o == handler_i && sel_miss); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !stall_o && !exc_o); // R11
endmodule

// File: tb/deadline_timer_unit_tb_top.sv
module deadline_timer_unit_tb_top;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  tid = '0;
  logic [1:0]  op = '0;
  logic [15:0] budget = '0;
  logic [31:0] pc = '0;
  logic [31:0] handler = '0;
  logic        stall, exc;
  logic [31:0] next_pc;

  int checks = 0;
  int failures = 0;
  int slot_no = 0;
  bit done = 0;

  int m_tmr [N];
  bit m_arm [N];
  bit m_miss [N];

  always #4 clk = ~clk;

  deadline_timer_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .tid_i(tid), .op_i(op),
    .budget_i(budget), .pc_i(pc), .handler_i(handler),
    .stall_o(stall), .next_pc_o(next_pc), .exc_o(exc)
  );

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic slot(input bit v, input int t, input int o, input int val, input string tag);
    bit isdead, e_exc, e_stall;
    logic [31:0] e_pc;
    string req;
    @(negedge clk);
    valid = v; tid = 3'(t); op = 2'(o); budget = 16'(val);
    pc = 32'h1000 + 32'(slot_no) * 4;
    handler = 32'h8000 + 32'(t) * 32;
    slot_no++;
    #1;
    isdead  = v && (o == 1 || o == 2);
    e_exc   = v && o == 2 && m_miss[t];
    e_stall = isdead && !e_exc && m_tmr[t] != 0;
    e_pc    = e_exc ? handler : (e_stall ? pc : pc + 32'd4);
    if (tag != "") req = tag;
    else if (e_exc) req = "R8";
    else if (e_stall) req = "R2";
    else if (isdead) req = "R3";
    else req = "R11";
    checks++;
    if (stall !== e_stall || exc !== e_exc || next_pc !== e_pc) begin
      failures++;
      $display("FAIL %s slot=%0d tid=%0d op=%0d: stall=%0b exc=%0b pc=%h expected stall=%0b exc=%0b pc=%h",
               req, slot_no, t, o, stall, exc, next_pc, e_stall, e_exc, e_pc);
    end
    if (v) begin
      if (isdead && !e_stall) begin
        m_tmr[t] = val;
        m_arm[t] = (val != 0);
        if (e_exc) m_miss[t] = 0;
      end else if (m_tmr[t] != 0) begin
        m_tmr[t]--;
      end else if (m_arm[t] && !isdead) begin
        m_miss[t] = 1;
        m_arm[t]  = 0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned r;
    for (int t = 0; t < N; t++) begin m_tmr[t] = 0; m_arm[t] = 0; m_miss[t] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (stall !== 1'b0 || exc !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: stall=%0b exc=%0b expected 0 0", stall, exc);
    end
    rst_n = 1'b1;
    // R1: first deadline on each thread completes
    for (int t = 0; t < N; t++) slot(1, t, 1, 0, "R1");
    slot(1, 2, 1, 3, "R3");
    slot(1, 2, 0, 0, "R11");
    slot(1, 2, 1, 9, "R2");
    slot(1, 4, 1, 0, "R4");
    slot(0, 2, 1, 0, "R4");
    slot(1, 2, 1, 9, "R2");
    slot(1, 2, 1, 2, "R3");
    slot(1, 2, 0, 0, "R4");
    slot(1, 2, 3, 0, "R11");
    slot(1, 2, 0, 0, "R6");
    slot(1, 2, 0, 0, "R5");
    slot(1, 2, 1, 1, "R10");
    slot(1, 2, 0, 0, "R5");
    slot(1, 2, 2, 4, "R10");
    for (int k = 0; k < 4; k++) slot(1, 2, 2, 0, "R9");
    slot(1, 2, 2, 0, "R9");
    for (int k = 0; k < 10; k++) slot(1, 2, 0, 0, "R7");
    slot(1, 2, 2, 5, "R7");
    // sweep: all threads interleaved, mixed ops, idle slots
    r = 32'h1234_5678;
    for (int i = 0; i < 6000; i++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      slot((r[31:29] != 3'd0), i % N, int'(r[27:26]), int'(r[24:21]) % 6, "");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule